// File: doc/BRIEF.md
# Equivalent-Time Step Response Capture Sequencer

The sequencer rebuilds a repeating step-load response at the resolution of the sample tick while storing only one point per load period. It drives a periodic load-switch output and counts sample ticks within each period. In every period it stores one word of the monitored data, and the capture instant moves one tick later relative to the load-on edge each time. After a start request the record builds up in an on-chip buffer, which a host reads back through a synchronous address/data port once the done flag rises.

The period (in ticks) and the number of points are sampled from the configuration inputs when start is asserted. The first tick counted after start has tick index 0. Period 0 is a quiet lead-in period with the load off. From period 1 onward the load is on for the first half of each period. Point 0 is taken on the last tick before the first load-on edge. Point k (k >= 1) is taken k-1 ticks after the load-on edge of period k. The stored record therefore covers the waveform from one tick before the edge out to N-2 ticks after it.

Top module: `etcap_seq`

## Requirements
- R1: After reset, done_o and load_sw_o are 0.
- R2: A start request clears done_o in the following cycle when the effective point count is nonzero. done_o rises in the cycle after the tick that stores the last point, and it stays high until the next start.
- R3: With effective period P (period_i, or 2 if period_i < 2), load_sw_o is high during tick index t exactly when t >= P, (t mod P) < floor(P/2), and the run has not finished. It is low whenever no run is active.
- R4: Buffer address 0 holds data_i sampled at tick index P-1, which is one tick before the first load-on edge.
- R5: For k >= 1, buffer address k holds data_i sampled at tick index k*P + k - 1, which is k-1 ticks after the load-on edge of period k.
- R6: Exactly one point is stored per period. The run ends after N points, at tick index (N-1)*P + N-2 for N >= 2 or P-1 for N = 1. Later ticks store nothing and leave load_sw_o low.
- R7: rd_data_o presents the word at rd_addr_i one clock after the address is applied. Until that edge it keeps its previous value.
- R8: The effective point count N is npts_i clamped to at most P and to at most the buffer depth. Buffer addresses at N and above keep their earlier contents.
- R9: A start with npts_i = 0 raises done_o in the next cycle. It produces no load switching and leaves the buffer unchanged.
- R10: A start during a run abandons that run and restarts from point 0 with the new configuration.
- R11: A tick asserted in the same cycle as start is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request; samples the configuration inputs |
| tick_i | input | 1 | Sample tick strobe, one cycle wide |
| data_i | input | DATA_W | Monitored controller variable |
| period_i | input | PER_W | Load-switch period in ticks |
| npts_i | input | CNT_W | Requested number of points |
| rd_addr_i | input | ADDR_W | Buffer read address |
| rd_data_o | output | DATA_W | Buffer read data, one cycle latency |
| load_sw_o | output | 1 | Load-switch drive |
| done_o | output | 1 | Record complete |

## Verification
The situation hardest to reach from the ports is the hand-off at the first load-on edge. Points 0 and 1 are captured on consecutive ticks that lie on opposite sides of the period wrap, and with ticks on every clock this means consecutive clock cycles. Back-to-back ticks exercise that case. Spaced ticks are run as well, with the data input driven as a known function of the bench's own tick count, so each stored word shows which tick it came from. An aborted run followed by a shorter run exposes stale addresses, and this shows both the restart from point 0 and the untouched region above the clamped count.

// File: rtl/etcap_pkg.sv
package etcap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_RUN  = 2'd1,
    CAP_DONE = 2'd2
  } cap_state_e;
endpackage

// File: rtl/etcap_phase.sv
module etcap_phase #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [PER_W-1:0] per_i,
  output logic [PER_W-1:0] per_o,
  output logic [PER_W-1:0] phase_o,
  output logic             pre_o,
  output logic             step_o,
  output logic             wrap_o,
  output logic             load_sw_o
);
  logic [PER_W-1:0] per_q, phase_q;
  logic             pre_q;

  assign step_o    = tick_i & run_i & ~restart_i;
  assign wrap_o    = step_o & (phase_q == per_q - PER_W'(1));
  assign per_o     = per_q;
  assign phase_o   = phase_q;
  assign pre_o     = pre_q;
  assign load_sw_o = run_i & ~pre_q & (phase_q < (per_q >> 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q   <= '0;
      phase_q <= '0;
      pre_q   <= 1'b1;
    end else if (restart_i) begin
      per_q   <= per_i;
      phase_q <= '0;
      pre_q   <= 1'b1;
    end else if (step_o) begin
      phase_q <= wrap_o ? '0 : phase_q + PER_W'(1);
      if (wrap_o) pre_q <= 1'b0;
    end
  end

  a_r3_phase_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (phase_q < per_q));
endmodule

// File: rtl/etcap_ctl.sv
module etcap_ctl
  import etcap_pkg::*;
#(
  parameter int PER_W  = 16,
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  n_i,
  input  logic [PER_W-1:0]  per_i,
  input  logic [PER_W-1:0]  phase_i,
  input  logic              step_i,
  input  logic              wrap_i,
  output logic              run_o,
  output logic              done_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  cap_state_e       st_q;
  logic [CNT_W-1:0] wp_q, n_q;
  logic             armed_q;
  logic [PER_W-1:0] tgt;
  logic             hit, last;

  // point 0 sits on the last tick of the lead-in period, point k on tick k-1 after its edge
  assign tgt  = (wp_q == '0) ? per_i - PER_W'(1) : PER_W'(wp_q) - PER_W'(1);
  assign hit  = step_i & armed_q & (st_q == CAP_RUN) & (phase_i == tgt);
  assign last = hit & ((wp_q + CNT_W'(1)) == n_q);

  assign run_o     = (st_q == CAP_RUN);
  assign done_o    = (st_q == CAP_DONE);
  assign wr_en_o   = hit;
  assign wr_addr_o = wp_q[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= CAP_IDLE;
      wp_q    <= '0;
      n_q     <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      st_q    <= (n_i == '0) ? CAP_DONE : CAP_RUN;
      wp_q    <= '0;
      n_q     <= n_i;
      armed_q <= 1'b1;
    end else if (step_i) begin
      armed_q <= wrap_i ? 1'b1 : (hit ? 1'b0 : armed_q);
      if (hit)  wp_q <= wp_q + CNT_W'(1);
      if (last) st_q <= CAP_DONE;
    end
  end

  a_r6_wp_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_q <= n_q);
  a_r2_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && n_i != '0) |=> !done_o);
  a_r2_done_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  a_r9_zero_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && n_i == '0) |=> done_o);
endmodule

// File: rtl/etcap_buf.sv
module etcap_buf #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= mem_q[rd_addr_i];
  end
endmodule

// File: rtl/etcap_seq.sv
module etcap_seq #(
  parameter int DATA_W = 16,
  parameter int PER_W  = 16,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int CNT_W  = ADDR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  npts_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              load_sw_o,
  output logic              done_o
);
  localparam int CMP_W = (PER_W > CNT_W) ? PER_W : CNT_W;

  logic [PER_W-1:0]  per_eff, per_q, phase;
  logic [CMP_W-1:0]  per_x, req_x, dep_x, n_x;
  logic [CNT_W-1:0]  n_eff;
  logic              pre, step, wrap, run, wr_en;
  logic [ADDR_W-1:0] wr_addr;

  assign per_eff = (period_i < PER_W'(2)) ? PER_W'(2) : period_i;
  assign per_x   = CMP_W'(per_eff);
  assign req_x   = CMP_W'(npts_i);
  assign dep_x   = CMP_W'(DEPTH);
  always_comb begin
    n_x = req_x;
    if (n_x > per_x) n_x = per_x;
    if (n_x > dep_x) n_x = dep_x;
  end
  assign n_eff = CNT_W'(n_x);

  etcap_phase #(.PER_W(PER_W)) u_phase (
    .clk_i, .rst_ni,
    .restart_i (start_i),
    .run_i     (run),
    .tick_i,
    .per_i     (per_eff),
    .per_o     (per_q),
    .phase_o   (phase),
    .pre_o     (pre),
    .step_o    (step),
    .wrap_o    (wrap),
    .load_sw_o
  );

  etcap_ctl #(.PER_W(PER_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctl (
    .clk_i, .rst_ni, .start_i,
    .n_i       (n_eff),
    .per_i     (per_q),
    .phase_i   (phase),
    .step_i    (step),
    .wrap_i    (wrap),
    .run_o     (run),
    .done_o,
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr)
  );

  etcap_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_buf (
    .clk_i, .rst_ni,
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (data_i),
    .rd_addr_i,
    .rd_data_o
  );

  a_r3_idle_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> !load_sw_o);
  a_r4_first_in_lead_in: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr == '0) |-> pre);
  a_r5_later_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && wr_addr != '0) |-> !pre);
  a_r2_done_not_running: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !run);
endmodule

// File: tb/etcap_seq_tb_top.sv
module etcap_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, tick_i = 1'b0;
  logic [15:0] data_i = '0;
  logic [15:0] period_i = '0;
  logic [10:0] npts_i = '0;
  logic [9:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic        load_sw_o, done_o;

  int total = 0, bad = 0;
  logic [15:0] shadow [DEPTH];
  bit          known  [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  etcap_seq dut_i (
    .clk_i(clk), .rst_ni, .start_i, .tick_i, .data_i, .period_i, .npts_i,
    .rd_addr_i, .rd_data_o, .load_sw_o, .done_o
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stim(input int mode, input int p, input int t);
    int pos;
    pos = t % p;
    if (mode == 0) return 16'((t * 7 + 3) & 16'hffff);
    if (t >= p && pos < p / 2) return 16'(4000 - (2048 >> (pos % 12)));
    return 16'(500 + pos * 3);
  endfunction

  function automatic int tick_of(input int p, input int k);
    return (k == 0) ? p - 1 : k * p + k - 1;
  endfunction

  // one full or aborted run; abort_at > 0 stops after that many ticks without readback
  task automatic run_capture(input int p_req, input int n_req, input int gap, input int mode,
                             input bit tick_with_start, input int abort_at);
    int p, n, t_last, t_end;
    p = (p_req < 2) ? 2 : p_req;
    n = n_req;
    if (n > p) n = p;
    if (n > DEPTH) n = DEPTH;
    t_last = (n == 1) ? p - 1 : (n - 1) * p + n - 2;
    @(negedge clk);
    period_i = 16'(p_req); npts_i = 11'(n_req);
    start_i = 1'b1; tick_i = tick_with_start; data_i = 16'hdead;
    @(negedge clk);
    start_i = 1'b0; tick_i = 1'b0;
    if (n == 0) begin
      chk("R9 done after zero-count start", int'(done_o), 1);
      for (int t = 0; t < 2 * p; t++) begin
        chk("R9 no load switching", int'(load_sw_o), 0);
        tick_i = 1'b1; data_i = 16'h5a5a;
        @(negedge clk);
        tick_i = 1'b0;
      end
      return;
    end
    chk("R2 start clears done", int'(done_o), 0);
    t_end = (abort_at > 0) ? abort_at - 1 : t_last + 3;
    for (int t = 0; t <= t_end; t++) begin
      if (t <= t_last)
        chk("R3 load switch pattern", int'(load_sw_o), int'(t >= p && (t % p) < p / 2));
      else
        chk("R6 no load after last point", int'(load_sw_o), 0);
      tick_i = 1'b1; data_i = stim(mode, p, t);
      @(negedge clk);
      tick_i = 1'b0;
      chk((t == t_last) ? "R6 done at last point tick" : "R2 done level", int'(done_o),
          int'(t >= t_last));
      repeat (gap) @(negedge clk);
    end
    for (int k = 0; k < n; k++) begin
      if (abort_at == 0 || tick_of(p, k) < abort_at) begin
        shadow[k] = stim(mode, p, tick_of(p, k));
        known[k]  = 1'b1;
      end
    end
    if (abort_at > 0) return;
    for (int a = 0; a < n + 2 && a < DEPTH; a++) begin
      if (a < n || known[a]) begin
        rd_addr_i = 10'(a);
        @(negedge clk);
        if (a == 0)      chk("R4 point before edge", int'(rd_data_o), int'(shadow[a]));
        else if (a < n)  chk("R5 interleaved point", int'(rd_data_o), int'(shadow[a]));
        else             chk("R8 address above count untouched", int'(rd_data_o), int'(shadow[a]));
      end
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk("R1 done after reset", int'(done_o), 0);
    chk("R1 load after reset", int'(load_sw_o), 0);
  endtask

  task automatic test_read_latency();
    rd_addr_i = 10'd2;
    @(negedge clk);
    chk("R7 data after one edge", int'(rd_data_o), int'(shadow[2]));
    rd_addr_i = 10'd3;
    #1;
    chk("R7 output held before edge", int'(rd_data_o), int'(shadow[2]));
    @(negedge clk);
    chk("R7 new address after edge", int'(rd_data_o), int'(shadow[3]));
  endtask

  task automatic test_zero_count();
    rd_addr_i = 10'd0;
    run_capture(6, 0, 0, 0, 1'b0, 0);
    @(negedge clk);
    chk("R9 buffer unchanged", int'(rd_data_o), int'(shadow[0]));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      shadow[i] = '0;
      known[i]  = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    test_reset();
    run_capture(8, 8, 0, 0, 1'b0, 0);     // back-to-back ticks, full record
    test_read_latency();
    run_capture(40, 40, 2, 1, 1'b0, 0);   // spaced ticks, step response
    run_capture(10, 15, 1, 0, 1'b1, 0);   // R8 clamp to period, R11 tick with start ignored
    run_capture(12, 12, 0, 1, 1'b0, 60);  // R10 aborted run
    run_capture(9, 3, 1, 0, 1'b0, 0);     // R10 restart from point 0, stale above
    run_capture(1, 5, 0, 0, 1'b0, 0);     // R3 period below 2 treated as 2
    test_zero_count();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule